// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock of an I2C master from its parent peripheral clock. It alternates a low phase, during which it pulls the clock line down, with a high phase, during which it lets the line go. Both phase lengths are whole multiples of one shared count, `ccr`. Software sets this count to the wanted clock period times the parent clock frequency. A speed select and a duty select then pick the multiples: symmetric in standard speed, and one of two uneven ratios in fast speed.

The generator runs while `enable` and `run` are both high. It reads the clock line back on `scl_in`. The high-phase count advances only on cycles where the line is seen high, so a target that holds the line low stretches the phase. A byte engine uses two single-cycle strobes. One marks the first cycle of every low phase. The other marks the data sample point in the middle of each high phase. Timing settings are captured only when a low phase begins, so a change made mid-period never cuts a phase short.

Top module: `scl_clkgen`

## Requirements
- R1: After reset, and whenever the block is idle, `scl_low` is 0 and both strobes are 0. With `enable` high and `run` low the block stays idle.
- R2: Standard speed (`fast_mode`=0, `duty_sel` ignored): the low phase lasts C cycles and the high phase lasts C cycles, where C is the effective count.
- R3: Fast speed with `duty_sel`=0: the high phase lasts C cycles and the low phase lasts 2·C cycles.
- R4: Fast speed with `duty_sel`=1: the high phase lasts 9·C cycles and the low phase lasts 16·C cycles.
- R5: The effective count C equals `ccr`, except that `ccr`=0 is used as 1.
- R6: During the high phase the count advances only on cycles where `scl_in` is 1. Each cycle with `scl_in` low lengthens the released time by one cycle.
- R7: `sample_pt` pulses exactly once per high phase, on a cycle where `scl_in` is 1. It falls on the counted high cycle with zero-based index floor((H-1)/2), where H is the high length.
- R8: `low_start` is 1 exactly on the first cycle of every low phase.
- R9: `ccr`, `fast_mode` and `duty_sel` are captured at the edge that starts a low phase. They govern that low phase and the high phase that follows it.
- R10: A period starts one cycle after an edge at which `enable` and `run` are both 1. `enable` low at an edge makes the block idle and releases the line on the next cycle.
- R11: `run` is checked at the end of each high phase. If it is low then, the block goes idle with the line released and starts no further low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Peripheral enable; low forces idle |
| run | input | 1 | Request to keep producing clock periods |
| ccr | input | 12 | Shared phase count in parent clock cycles |
| fast_mode | input | 1 | 0 = standard speed, 1 = fast speed |
| duty_sel | input | 1 | Fast-speed ratio: 0 = 1:2, 1 = 9:16 (high:low) |
| scl_in | input | 1 | Clock line as read back from the bus |
| scl_low | output | 1 | 1 = pull the clock line low, 0 = release |
| low_start | output | 1 | Strobe on the first cycle of each low phase |
| sample_pt | output | 1 | Strobe at the data sample point of each high phase |

## Verification
The first low cycle appears one cycle after the edge that sees `enable` and `run`. From then on every output is decoded from registered state, so each phase's length shows up as a run of cycles on `scl_low` that can be counted. A release after `enable` drops is due exactly one cycle later. The bench computes the low length, released length and sample-point index of every period in advance. The monitor counts these one sample per cycle, at the falling clock edge, and compares them when each run ends. The model of the bus line updates shortly after the rising edge, so the stretched cycles it inserts line up exactly with the cycles the design sees.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;

    localparam int MULT_W = 5;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic [MULT_W-1:0] hi_m;
        logic [MULT_W-1:0] lo_m;
    } mult_t;

    // Multiples of the shared count for each speed/duty combination
    function automatic mult_t pick_mult(input logic fast, input logic duty);
        mult_t m;
        if (!fast) begin
            m.hi_m = MULT_W'(1);
            m.lo_m = MULT_W'(1);
        end else if (!duty) begin
            m.hi_m = MULT_W'(1);
            m.lo_m = MULT_W'(2);
        end else begin
            m.hi_m = MULT_W'(9);
            m.lo_m = MULT_W'(16);
        end
        return m;
    endfunction

endpackage

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
    parameter int CCR_W = 12,
    parameter int CNT_W = CCR_W + scl_clkgen_pkg::MULT_W
) (
    input  logic [CCR_W-1:0] ccr,
    input  logic             fast,
    input  logic             duty,
    output logic [CNT_W-1:0] lo_len,
    output logic [CNT_W-1:0] hi_len
);
    import scl_clkgen_pkg::*;

    logic [CNT_W-1:0] base;
    mult_t            m;

    always_comb begin
        base   = (ccr == '0) ? CNT_W'(1) : CNT_W'(ccr);
        m      = pick_mult(fast, duty);
        lo_len = base * CNT_W'(m.lo_m);
        hi_len = base * CNT_W'(m.hi_m);
    end
endmodule

// File: rtl/scl_len_hold.sv
module scl_len_hold #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= W'(1);
        else if (load) q <= d;
    end
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         zero
);
    always_ff @(posedge clk) begin
        if (rst)                 cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (dec && !zero)   cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
    parameter int CCR_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             run,
    input  logic [CCR_W-1:0] ccr,
    input  logic             fast_mode,
    input  logic             duty_sel,
    input  logic             scl_in,
    output logic             scl_low,
    output logic             low_start,
    output logic             sample_pt
);
    import scl_clkgen_pkg::*;

    localparam int CNT_W = CCR_W + MULT_W;

    phase_e           ph;
    logic             first_q;
    logic [CNT_W-1:0] lo_in, hi_in, hi_q, cnt, cnt_load_val;
    logic             cnt_zero, cnt_load, cnt_dec;
    logic             start_low, start_high, end_high;
    logic             st_idle, st_high;

    scl_phase_len #(.CCR_W(CCR_W), .CNT_W(CNT_W)) u_len (
        .ccr    (ccr),
        .fast   (fast_mode),
        .duty   (duty_sel),
        .lo_len (lo_in),
        .hi_len (hi_in)
    );

    // High length is frozen when a low phase begins
    scl_len_hold #(.W(CNT_W)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (start_low),
        .d    (hi_in),
        .q    (hi_q)
    );

    scl_phase_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .dec      (cnt_dec),
        .cnt      (cnt),
        .zero     (cnt_zero)
    );

    always_comb begin
        end_high     = (ph == PH_HIGH) && scl_in && cnt_zero;
        start_low    = enable && run && ((ph == PH_IDLE) || end_high);
        start_high   = enable && (ph == PH_LOW) && cnt_zero;
        cnt_load     = start_low || start_high;
        cnt_load_val = start_low ? (lo_in - CNT_W'(1)) : (hi_q - CNT_W'(1));
        cnt_dec      = (ph == PH_LOW) || ((ph == PH_HIGH) && scl_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            first_q <= 1'b0;
        end else begin
            first_q <= start_low;
            if (!enable) begin
                ph <= PH_IDLE;
            end else begin
                case (ph)
                    PH_IDLE: if (run)        ph <= PH_LOW;
                    PH_LOW:  if (cnt_zero)   ph <= PH_HIGH;
                    PH_HIGH: if (end_high)   ph <= run ? PH_LOW : PH_IDLE;
                    default:                 ph <= PH_IDLE;
                endcase
            end
        end
    end

    assign st_idle   = (ph == PH_IDLE);
    assign st_high   = (ph == PH_HIGH);
    assign scl_low   = (ph == PH_LOW);
    assign low_start = first_q && (ph == PH_LOW);
    assign sample_pt = st_high && scl_in && (cnt == (hi_q >> 1));
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic scl_in,
    input logic scl_low,
    input logic low_start,
    input logic sample_pt,
    input logic st_idle,
    input logic st_high
);
    // R1: idle means released line and quiet strobes
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        st_idle |-> (!scl_low && !low_start && !sample_pt));

    // R10: enable low releases the line on the next cycle
    a_r10_enable_release: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !scl_low);

    // R8: low_start marks exactly the rising edge of the low drive
    a_r8_start_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_low) |-> low_start);
    a_r8_start_only_rise: assert property (@(posedge clk) disable iff (rst)
        low_start |-> $rose(scl_low));

    // R7: sample point only while released and the line is high
    a_r7_sample_released: assert property (@(posedge clk) disable iff (rst)
        sample_pt |-> (!scl_low && scl_in));

    // R6: a stretched high phase does not end
    a_r6_stretch_holds: assert property (@(posedge clk) disable iff (rst)
        (st_high && !scl_in && enable) |=> st_high);
endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .scl_in    (scl_in),
    .scl_low   (scl_low),
    .low_start (low_start),
    .sample_pt (sample_pt),
    .st_idle   (st_idle),
    .st_high   (st_high)
);

// File: tb/scl_clkgen_bench.sv
module scl_clkgen_bench;

    typedef struct {
        int lo;
        int hi;
        int sp;
        bit last;
    } period_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        run = 1'b0;
    logic [11:0] ccr = 12'd1;
    logic        fast_mode = 1'b0;
    logic        duty_sel = 1'b0;
    logic        scl_in;
    logic        scl_low, low_start, sample_pt;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bus line model: stretch S cycles after each release
    int stretch_amt = 0;
    int stretch_left = 0;
    bit prev_dl = 1'b0;

    period_t exp_q[$];
    bit mon_on = 1'b0;

    always #5 clk = ~clk;

    scl_clkgen u_scl_clkgen (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .run       (run),
        .ccr       (ccr),
        .fast_mode (fast_mode),
        .duty_sel  (duty_sel),
        .scl_in    (scl_in),
        .scl_low   (scl_low),
        .low_start (low_start),
        .sample_pt (sample_pt)
    );

    assign scl_in = !scl_low && (stretch_left == 0);

    always @(posedge clk) begin
        #2;
        if (scl_low) stretch_left = stretch_amt;
        else if (!prev_dl && stretch_left > 0) stretch_left = stretch_left - 1;
        prev_dl = scl_low;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic period_t make_item(input int c, input bit f, input bit d,
                                          input int s, input bit last);
        period_t p;
        int ce, hm, lm;
        ce = (c == 0) ? 1 : c;             // R5
        if (!f)      begin hm = 1; lm = 1;  end   // R2
        else if (!d) begin hm = 1; lm = 2;  end   // R3
        else         begin hm = 9; lm = 16; end   // R4
        p.lo = lm * ce;
        p.hi = hm * ce + s;                       // R6
        p.sp = s + (hm * ce - 1) / 2;             // R7
        p.last = last;
        return p;
    endfunction

    // monitor / scoreboard
    period_t cur;
    bit cur_low = 1'b0, in_high = 1'b0, done = 1'b1;
    int lo_cnt, hi_cnt, sp_n, sp_pos;

    task automatic finish_high();
        check(hi_cnt == cur.hi, "R2/R3/R4/R6 released length", hi_cnt, cur.hi);
        check(sp_n == 1, "R7 sample pulses per high", sp_n, 1);
        check(sp_pos == cur.sp, "R7 sample index", sp_pos, cur.sp);
        done = 1'b1;
    endtask

    always @(negedge clk) begin
        if (!mon_on) begin
            cur_low = 1'b0; in_high = 1'b0; done = 1'b1;
        end else if (scl_low) begin
            if (!cur_low) begin
                if (in_high && !done) finish_high();
                in_high = 1'b0;
                check(low_start == 1'b1, "R8 low_start on first low cycle", low_start, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11 unexpected period", 1, 0);
                    cur = '{lo: -1, hi: -1, sp: -1, last: 1'b1};
                end else begin
                    cur = exp_q.pop_front();
                end
                cur_low = 1'b1;
                lo_cnt = 0;
            end else begin
                check(low_start == 1'b0, "R8 low_start later in low", low_start, 0);
            end
            lo_cnt++;
        end else begin
            if (cur_low) begin
                check(lo_cnt == cur.lo, "R2/R3/R4/R9 low length", lo_cnt, cur.lo);
                cur_low = 1'b0; in_high = 1'b1; done = 1'b0;
                hi_cnt = 0; sp_n = 0; sp_pos = -1;
            end
            if (low_start) check(1'b0, "R8 low_start while released", 1, 0);
            if (in_high && !done) begin
                if (sample_pt) begin sp_n++; sp_pos = hi_cnt; end
                hi_cnt++;
                if (cur.last && hi_cnt == cur.hi) finish_high();
            end else if (sample_pt) begin
                check(1'b0, "R1 sample_pt while idle", 1, 0);
            end
        end
    end

    // driver: pre-pushes expected periods, then runs the burst
    task automatic burst(input int n, input int ca, input bit fa, input bit da,
                         input int m, input int cb, input bit fb, input bit db,
                         input int s);
        int lows = 0;
        bit dprev = 1'b0;
        period_t tail;
        for (int i = 1; i <= n; i++) begin
            if (m > 0 && i > m) exp_q.push_back(make_item(cb, fb, db, s, i == n));
            else                exp_q.push_back(make_item(ca, fa, da, s, i == n));
        end
        tail = exp_q[exp_q.size() - 1];
        @(negedge clk);
        ccr = 12'(ca); fast_mode = fa; duty_sel = da; stretch_amt = s;
        enable = 1'b1; run = 1'b1;
        while (lows < n) begin
            @(negedge clk);
            if (scl_low && !dprev) begin
                lows++;
                if (lows == m) begin ccr = 12'(cb); fast_mode = fb; duty_sel = db; end  // R9
                if (lows == n) run = 1'b0;                                           // R11
            end
            dprev = scl_low;
        end
        repeat (tail.lo + tail.hi + 6) @(negedge clk);
        check(exp_q.size() == 0, "R11 no extra period", exp_q.size(), 0);
        check(scl_low == 1'b0, "R11 released after run drop", scl_low, 0);
        check(done == 1'b1, "R11 last high completed", done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(scl_low == 0 && low_start == 0 && sample_pt == 0, "R1 reset state",
              {scl_low, low_start, sample_pt}, 0);
        rst = 1'b0;
        mon_on = 1'b1;

        // R1: enable without run stays idle
        enable = 1'b1;
        repeat (8) @(negedge clk);
        check(scl_low == 0 && low_start == 0, "R1 idle with run low", scl_low, 0);
        enable = 1'b0;

        burst(3, 3, 0, 0, 0, 0, 0, 0, 0);   // R2 standard, C=3
        burst(3, 4, 1, 0, 0, 0, 0, 0, 0);   // R3 fast 1:2, C=4
        burst(2, 2, 1, 1, 0, 0, 0, 0, 0);   // R4 fast 9:16, C=2 -> 32/18
        burst(2, 0, 0, 0, 0, 0, 0, 0, 0);   // R5 zero count as one, standard
        burst(2, 0, 1, 0, 0, 0, 0, 0, 0);   // R5 zero count, fast 1:2
        burst(3, 4, 0, 0, 0, 0, 0, 0, 5);   // R6 stretched high phase
        burst(3, 3, 0, 0, 1, 1, 1, 1, 0);   // R9 change during period 1
        burst(2, 5, 1, 1, 0, 0, 0, 0, 2);   // R4/R6/R7 long high with stretch

        // R10: enable drop in mid low phase
        mon_on = 1'b0;
        @(negedge clk);
        ccr = 12'd6; fast_mode = 1'b0; stretch_amt = 0;
        enable = 1'b1; run = 1'b1;
        @(negedge clk);
        check(scl_low == 1'b1, "R10 period starts one cycle after request", scl_low, 1);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(scl_low == 1'b0, "R10 release one cycle after enable drop", scl_low, 0);
        repeat (10) @(negedge clk);
        check(scl_low == 0 && sample_pt == 0 && low_start == 0, "R10 stays idle",
              {scl_low, sample_pt, low_start}, 0);
        run = 1'b0;

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule